// File: doc/BRIEF.md
# Peripheral enable and address router

This block holds the enable settings for a set of on-chip extension units and steers every bus access either to one of their chip selects or to the external memory interface. A 16-bit configuration register carries one enable bit per unit. Software writes it during start-up. Once the system raises its global extension-peripheral enable flag, the register is frozen and later writes have no effect.

For each strobed 24-bit access, the decoder picks exactly one outcome: a unit chip select, an external-access request, or an unclaimed-access pulse. Three units (two CAN controllers and a PWM unit) share one 1 KB window in segment 0. That window falls through to external memory only when all three sharers are disabled. A hit on a disabled sharer's page while another sharer is enabled is reported as unclaimed. The block also flags which port pins the disabled CAN controllers release back to general-purpose I/O.

Top module: `xper_router`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0005. This means CAN1 (bit 0) and on-chip RAM (bit 2) are enabled, and CAN2 (bit 1), grouped port/timer/ADC-mux (bit 3) and PWM (bit 4) are disabled.
- R2: A write with `glob_en` low loads `cfg_wdata[4:0]` into the enable bits at the next clock edge. `cfg_rdata[15:5]` always reads zero, whatever was written.
- R3: While `glob_en` is high, writes are ignored. The readback and the routing keep their previous values.
- R4: With its bit set, CAN1 takes 0x00EF00–0x00EFFF (`cs_can1`), CAN2 takes 0x00EE00–0x00EEFF (`cs_can2`), and PWM takes 0x00EC00–0x00ECFF (`cs_pwm`).
- R5: Any access in 0x00EC00–0x00EFFF, including 0x00ED00–0x00EDFF, raises `ext_req` only when bits 0, 1 and 4 are all clear.
- R6: If at least one of bits 0, 1 and 4 is set, an access in the shared window that no enabled unit claims raises `unclaimed`, with no chip select and no `ext_req`.
- R7: An access in the RAM window (default 0x00E000–0x00FFFF, minus the shared window) raises `cs_ram` when bit 2 is set, and `ext_req` otherwise.
- R8: An access in the grouped window (default 0x00C000–0x00C0FF) raises `cs_grp` when bit 3 is set, and `ext_req` otherwise.
- R9: An access outside all internal windows, including any segment other than 0, raises `ext_req`.
- R10: `pin_gpio_rel[0]` (pin 4.4) and `pin_gpio_rel[3]` (pin 4.7) are high exactly when CAN2 is disabled. `pin_gpio_rel[1]` (pin 4.5) and `pin_gpio_rel[2]` (pin 4.6) are high exactly when CAN1 is disabled.
- R11: Each cycle with `acc_valid` high raises exactly one of the five chip selects, `ext_req` and `unclaimed`. With `acc_valid` low, all seven are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| glob_en | input | 1 | Global extension-peripheral enable; locks the register |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 24 | Access address |
| cs_can1 | output | 1 | CAN1 chip select |
| cs_can2 | output | 1 | CAN2 chip select |
| cs_ram | output | 1 | On-chip RAM chip select |
| cs_grp | output | 1 | Grouped port/timer/ADC-mux chip select |
| cs_pwm | output | 1 | PWM chip select |
| ext_req | output | 1 | External memory access request |
| unclaimed | output | 1 | Access hit a disabled unit inside a live shared window |
| pin_gpio_rel | output | 4 | Pin release flags for pins 4.4, 4.5, 4.6, 4.7 |

## Verification
The assertions check three things on every cycle: the register stays frozen while the lock is held, an unlocked write lands, and every strobed access produces exactly one outcome with nothing asserted when idle. They also check that the shared window never goes external while a sharer is enabled, and that paired pin flags move together. Only the bench's sweep can show that each outcome is the right one for its address. That sweep covers all 32 enable settings, every 256-byte page from 0x00C000 to 0x00FFFF at both page edges, and addresses in other segments. It also covers the reset value and writes under the lock.

// File: rtl/xrt_pkg.sv
package xrt_pkg;
  localparam int N_UNITS  = 5;
  localparam int U_CAN1   = 0;
  localparam int U_CAN2   = 1;
  localparam int U_RAM    = 2;
  localparam int U_GRP    = 3;
  localparam int U_PWM    = 4;
  localparam int N_SHARED = 3;

  // unit index of each sharer of the peripheral window
  function automatic int shared_unit(input int g);
    case (g)
      0:       return U_CAN1;
      1:       return U_CAN2;
      default: return U_PWM;
    endcase
  endfunction
endpackage

// File: rtl/xrt_rst_sync.sv
module xrt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xrt_enable_reg.sv
module xrt_enable_reg #(
  parameter int              DATA_W  = 16,
  parameter int              N_EN    = 5,
  parameter logic [DATA_W-1:0] RST_VAL = 16'h0005
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              glob_en,
  output logic [DATA_W-1:0] cfg_q
);
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << N_EN) - 1);

  logic              wr_ce;
  logic [DATA_W-1:0] cfg_d;

  always_comb begin
    wr_ce = cfg_wr & ~glob_en;
    cfg_d = cfg_q;
    if (wr_ce) cfg_d = cfg_wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= RST_VAL & KEEP_MASK;
    else        cfg_q <= cfg_d;
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    glob_en |=> $stable(cfg_q)); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !glob_en) |=> (cfg_q[N_EN-1:0] == $past(cfg_wdata[N_EN-1:0]))); // R2
endmodule

// File: rtl/xrt_addr_decode.sv
module xrt_addr_decode
  import xrt_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] WIN_LO   = 24'h00EC00,
  parameter logic [ADDR_W-1:0] WIN_HI   = 24'h00EFFF,
  parameter logic [ADDR_W-1:0] CAN1_LO  = 24'h00EF00,
  parameter logic [ADDR_W-1:0] CAN2_LO  = 24'h00EE00,
  parameter logic [ADDR_W-1:0] PWM_LO   = 24'h00EC00,
  parameter int                SUB_SPAN = 256,
  parameter logic [ADDR_W-1:0] RAM_LO   = 24'h00E000,
  parameter logic [ADDR_W-1:0] RAM_HI   = 24'h00FFFF,
  parameter logic [ADDR_W-1:0] GRP_LO   = 24'h00C000,
  parameter logic [ADDR_W-1:0] GRP_HI   = 24'h00C0FF
) (
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [N_UNITS-1:0] en,
  output logic [N_UNITS-1:0] sel,
  output logic               ext_req,
  output logic               unclaimed
);
  localparam logic [ADDR_W-1:0] SUB_LAST = ADDR_W'(SUB_SPAN - 1);

  logic [N_SHARED-1:0] claim_g;

  for (genvar g = 0; g < N_SHARED; g++) begin : g_share
    localparam logic [ADDR_W-1:0] LO = (g == 0) ? CAN1_LO : (g == 1) ? CAN2_LO : PWM_LO;
    localparam logic [ADDR_W-1:0] HI = LO + SUB_LAST;
    assign claim_g[g] = (acc_addr >= LO) && (acc_addr <= HI) && en[shared_unit(g)];
  end

  logic in_win, in_ram, in_grp, share_live;

  always_comb begin
    in_win     = (acc_addr >= WIN_LO) && (acc_addr <= WIN_HI);
    in_ram     = (acc_addr >= RAM_LO) && (acc_addr <= RAM_HI) && !in_win;
    in_grp     = (acc_addr >= GRP_LO) && (acc_addr <= GRP_HI) && !in_win && !in_ram;
    share_live = 1'b0;
    for (int g = 0; g < N_SHARED; g++) share_live = share_live | en[shared_unit(g)];

    sel       = '0;
    ext_req   = 1'b0;
    unclaimed = 1'b0;
    if (acc_valid) begin
      if (in_win) begin
        if (|claim_g) begin
          for (int g = 0; g < N_SHARED; g++)
            if (claim_g[g]) sel[shared_unit(g)] = 1'b1;
        end else if (!share_live) begin
          ext_req = 1'b1;
        end else begin
          unclaimed = 1'b1;
        end
      end else if (in_ram) begin
        if (en[U_RAM]) sel[U_RAM] = 1'b1;
        else           ext_req    = 1'b1;
      end else if (in_grp) begin
        if (en[U_GRP]) sel[U_GRP] = 1'b1;
        else           ext_req    = 1'b1;
      end else begin
        ext_req = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xper_router.sv
module xper_router
  import xrt_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] RST_VAL  = 16'h0005,
  parameter logic [ADDR_W-1:0] RAM_LO   = 24'h00E000,
  parameter logic [ADDR_W-1:0] RAM_HI   = 24'h00FFFF,
  parameter logic [ADDR_W-1:0] GRP_LO   = 24'h00C000,
  parameter logic [ADDR_W-1:0] GRP_HI   = 24'h00C0FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              glob_en,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              cs_can1,
  output logic              cs_can2,
  output logic              cs_ram,
  output logic              cs_grp,
  output logic              cs_pwm,
  output logic              ext_req,
  output logic              unclaimed,
  output logic [3:0]        pin_gpio_rel
);
  localparam logic [ADDR_W-1:0] WIN_LO = 24'h00EC00;
  localparam logic [ADDR_W-1:0] WIN_HI = 24'h00EFFF;

  logic               rst_sync_n;
  logic [DATA_W-1:0]  cfg_q;
  logic [N_UNITS-1:0] sel;

  xrt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  xrt_enable_reg #(.DATA_W(DATA_W), .N_EN(N_UNITS), .RST_VAL(RST_VAL)) u_reg (
    .clk(clk), .rst_n(rst_sync_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .glob_en(glob_en), .cfg_q(cfg_q)
  );

  xrt_addr_decode #(
    .ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
    .CAN1_LO(24'h00EF00), .CAN2_LO(24'h00EE00), .PWM_LO(24'h00EC00), .SUB_SPAN(256),
    .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .GRP_LO(GRP_LO), .GRP_HI(GRP_HI)
  ) u_dec (
    .acc_valid(acc_valid), .acc_addr(acc_addr), .en(cfg_q[N_UNITS-1:0]),
    .sel(sel), .ext_req(ext_req), .unclaimed(unclaimed)
  );

  assign cfg_rdata    = cfg_q;
  assign cs_can1      = sel[U_CAN1];
  assign cs_can2      = sel[U_CAN2];
  assign cs_ram       = sel[U_RAM];
  assign cs_grp       = sel[U_GRP];
  assign cs_pwm       = sel[U_PWM];
  assign pin_gpio_rel = {~cfg_q[U_CAN2], ~cfg_q[U_CAN1], ~cfg_q[U_CAN1], ~cfg_q[U_CAN2]};

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_valid |-> ($countones({sel, ext_req, unclaimed}) == 1)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_valid |-> ({sel, ext_req, unclaimed} == '0)); // R11

  AST_WIN_EXT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && ext_req && acc_addr >= WIN_LO && acc_addr <= WIN_HI)
      |-> (cfg_rdata[U_CAN1] == 1'b0 && cfg_rdata[U_CAN2] == 1'b0 && cfg_rdata[U_PWM] == 1'b0)); // R5

  AST_PIN_PAIRS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pin_gpio_rel[0] == pin_gpio_rel[3]) && (pin_gpio_rel[1] == pin_gpio_rel[2])); // R10
endmodule

// File: tb/tb_xper_router.sv
module tb_xper_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        glob_en = 1'b0;
  logic        acc_valid = 1'b0;
  logic [23:0] acc_addr = '0;
  logic        cs_can1, cs_can2, cs_ram, cs_grp, cs_pwm, ext_req, unclaimed;
  logic [3:0]  pin_gpio_rel;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  xper_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .glob_en(glob_en), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .cs_can1(cs_can1), .cs_can2(cs_can2), .cs_ram(cs_ram), .cs_grp(cs_grp), .cs_pwm(cs_pwm),
    .ext_req(ext_req), .unclaimed(unclaimed), .pin_gpio_rel(pin_gpio_rel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // outcome vector {unclaimed, ext, pwm, grp, ram, can2, can1}
  function automatic logic [6:0] model(input logic [23:0] a, input logic [4:0] en);
    logic [6:0] r = '0;
    logic claimed;
    if (a[23:16] == 8'h00 && a[15:8] >= 8'hEC && a[15:8] <= 8'hEF) begin
      claimed = 1'b0;
      if (a[15:8] == 8'hEF && en[0]) begin r[0] = 1'b1; claimed = 1'b1; end
      if (a[15:8] == 8'hEE && en[1]) begin r[1] = 1'b1; claimed = 1'b1; end
      if (a[15:8] == 8'hEC && en[4]) begin r[4] = 1'b1; claimed = 1'b1; end
      if (!claimed) begin
        if (!en[0] && !en[1] && !en[4]) r[5] = 1'b1;
        else                            r[6] = 1'b1;
      end
    end else if (a[23:16] == 8'h00 && a[15:13] == 3'b111) begin
      if (en[2]) r[2] = 1'b1; else r[5] = 1'b1;
    end else if (a[23:16] == 8'h00 && a[15:8] == 8'hC0) begin
      if (en[3]) r[3] = 1'b1; else r[5] = 1'b1;
    end else begin
      r[5] = 1'b1;
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [23:0] a, input logic [6:0] e);
    if (a[23:16] == 8'h00 && a[15:8] >= 8'hEC && a[15:8] <= 8'hEF)
      return e[6] ? "R6" : (e[5] ? "R5" : "R4");
    if (a[23:16] == 8'h00 && a[15:13] == 3'b111) return "R7";
    if (a[23:16] == 8'h00 && a[15:8] == 8'hC0) return "R8";
    return "R9";
  endfunction

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic probe(input logic [23:0] a, input logic [4:0] en);
    logic [6:0] e;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a;
    #2;
    e = model(a, en);
    check(tag_of(a, e), {25'b0, unclaimed, ext_req, cs_pwm, cs_grp, cs_ram, cs_can2, cs_can1},
          {25'b0, e});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 reset value", {16'b0, cfg_rdata}, 32'h0005);
    check("R10 reset pins", {28'b0, pin_gpio_rel}, 32'h9);
    probe(24'h00EF10, 5'h05);
    probe(24'h00EE10, 5'h05);

    // R2: upper bits never stored
    write_cfg(16'hFFE0);
    #1;
    check("R2 unused bits", {16'b0, cfg_rdata}, 32'h0);

    for (int cfg = 0; cfg < 32; cfg++) begin
      write_cfg(16'(cfg));
      #1;
      check("R2 readback", {16'b0, cfg_rdata}, 32'(cfg));
      check("R10 pins", {28'b0, pin_gpio_rel},
            {28'b0, ~cfg[1], ~cfg[0], ~cfg[0], ~cfg[1]});
      for (int p = 8'hC0; p <= 8'hFF; p++) begin
        probe({8'h00, 8'(p), 8'h00}, 5'(cfg));
        probe({8'h00, 8'(p), 8'hFF}, 5'(cfg));
      end
      probe(24'h00BFFF, 5'(cfg));
      probe(24'h01EF00, 5'(cfg));
      probe(24'h10C010, 5'(cfg));
      probe(24'h01E800, 5'(cfg));
      @(negedge clk);
      acc_valid = 1'b0;
      #2;
      check("R11 idle", {25'b0, unclaimed, ext_req, cs_pwm, cs_grp, cs_ram, cs_can2, cs_can1}, 32'h0);
    end

    // R3: lock
    write_cfg(16'h0013);
    @(negedge clk);
    glob_en = 1'b1;
    write_cfg(16'h000C);
    #1;
    check("R3 locked readback", {16'b0, cfg_rdata}, 32'h0013);
    check("R3 locked pins", {28'b0, pin_gpio_rel}, 32'h0);
    probe(24'h00E100, 5'h13);
    probe(24'h00EC40, 5'h13);
    glob_en = 1'b0;
    write_cfg(16'h000C);
    #1;
    check("R3 unlocked write", {16'b0, cfg_rdata}, 32'h000C);
    probe(24'h00ED00, 5'h0C);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule